// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes a single PWM waveform and routes it to any combination of four output pins, named A, B, C and D. Each pin has its own steering enable. A pin that is not steered carries its general-purpose port data bit. Pin pairs A/C and B/D each have a polarity bit that sets the active level of the PWM they carry. Port data is never inverted.

One configuration write sets the enables, the synchronization choice and the two polarity bits. With synchronization off, a new set of enables takes effect on the clock after the write. With synchronization on, the new set waits for the next PWM period-start pulse, so every steered pin shows only whole PWM periods.

An auto-shutdown request forces only the steered pins to a level chosen per pin pair. The pins that carry port data keep their port data during shutdown.

Top module: `pwm_steer`

## Requirements
- R1: After reset, every steering enable is 0, synchronization is off and both polarities are active-high. Every pin then outputs its port data bit.
- R2: A pin whose active steering enable is 1 outputs the PWM input. Any number of pins, from one to all four, can carry it at the same time. The configuration word bits 3..0 are the enables for pins D, C, B, A, with A at bit 0.
- R3: A pin whose active steering enable is 0 outputs its port data bit, whatever the PWM input does.
- R4: Configuration bit 5 set to 1 makes pins A and C active-low, which means they carry the inverted PWM. Bit 6 does the same for pins B and D. Polarity takes effect in the cycle after the write and never inverts port data.
- R5: When a write clears configuration bit 4 (synchronization off), the new enables appear on the pins one clock after the clock that captures the write. Until then the old enables hold.
- R6: When a write sets bit 4 (synchronization on), the new enables stay pending. They take effect at the first clock, after the capturing clock, where the period-start input is 1. A period-start pulse in the same cycle as the write does not apply them.
- R7: While the shutdown request is 1, each steered pin is driven by its pair's 2-bit shutdown code. Code 00 drives 0, code 01 drives 1, and codes 10 and 11 drive the inactive level for that pair's polarity: 0 for active-high and 1 for active-low.
- R8: The shutdown request has no effect on pins whose active steering enable is 0. Those pins keep outputting port data.
- R9: A second write while enables are still pending replaces the pending value. Only the later value is applied.
- R10: With all four enables at 0, no pin shows the PWM signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | NPINS+3 | Configuration word: enables, sync bit, A/C polarity, B/D polarity |
| pwm_i | input | 1 | PWM waveform to steer |
| period_start_i | input | 1 | One-cycle pulse at the start of each PWM period |
| port_i | input | NPINS | Port data for each pin when it is not steered |
| sd_req_i | input | 1 | Auto-shutdown request |
| sd_lvl_ac_i | input | 2 | Shutdown level code for pins A and C |
| sd_lvl_bd_i | input | 2 | Shutdown level code for pins B and D |
| pin_o | output | NPINS | Pin outputs, bit 0 = A |

## Verification
Two events can land on the same clock edge: a synchronized configuration write and a period-start pulse. The bench raises both strobes in one cycle and expects the old enables to survive that edge and one more idle cycle. It then expects the new enables only after a later period-start pulse. The bench also raises the shutdown request while some pins are steered and the others carry port data. It steps through the shutdown codes under both polarities and checks that each steered pin holds its forced level and each unsteered pin keeps its port bit.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    // Shutdown level codes per pin pair
    typedef enum logic [1:0] {
        SD_DRIVE_LOW  = 2'b00,
        SD_DRIVE_HIGH = 2'b01,
        SD_IDLE_A     = 2'b10,
        SD_IDLE_B     = 2'b11
    } sd_code_e;

    // Level forced on a steered pin during shutdown
    function automatic logic sd_level(input logic [1:0] code, input logic active_low);
        logic lvl;
        case (code)
            SD_DRIVE_LOW:  lvl = 1'b0;
            SD_DRIVE_HIGH: lvl = 1'b1;
            default:       lvl = active_low; // inactive level of the pair
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs #(
    parameter int NPINS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [NPINS+2:0]   wdata_i,
    input  logic               period_start_i,
    output logic [NPINS-1:0]   act_en_o,
    output logic               pol_ac_o,
    output logic               pol_bd_o
);

    localparam int SYNC_BIT   = NPINS;
    localparam int POL_AC_BIT = NPINS + 1;
    localparam int POL_BD_BIT = NPINS + 2;

    typedef struct packed {
        logic [NPINS-1:0] shadow;
        logic             pend;
        logic [NPINS-1:0] act;
        logic             sync;
        logic             pol_ac;
        logic             pol_bd;
    } st_t;

    st_t st_d, st_q;
    logic apply;

    always_comb begin
        st_d  = st_q;
        apply = st_q.pend && (!st_q.sync || period_start_i);
        if (apply) begin
            st_d.act  = st_q.shadow;
            st_d.pend = 1'b0;
        end
        if (we_i) begin
            st_d.shadow = wdata_i[NPINS-1:0];
            st_d.pend   = 1'b1;
            st_d.sync   = wdata_i[SYNC_BIT];
            st_d.pol_ac = wdata_i[POL_AC_BIT];
            st_d.pol_bd = wdata_i[POL_BD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_en_o = st_q.act;
    assign pol_ac_o = st_q.pol_ac;
    assign pol_bd_o = st_q.pol_bd;

    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sync && !period_start_i) |=> $stable(st_q.act));

    // R5
    imm_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !st_q.sync) |=> (st_q.act == $past(st_q.shadow)));

    // R9
    write_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (st_q.pend && st_q.shadow == $past(wdata_i[NPINS-1:0])));

endmodule

// File: rtl/pwm_steer_lane.sv
module pwm_steer_lane
    import pwm_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       pwm_i,
    input  logic       port_i,
    input  logic       pol_i,
    input  logic       sd_req_i,
    input  logic [1:0] sd_lvl_i,
    output logic       pin_o
);

    logic steered;

    always_comb begin
        // polarity is applied after selection of the PWM
        steered = pwm_i ^ pol_i;
        if (!en_i) begin
            pin_o = port_i;
        end else if (sd_req_i) begin
            pin_o = sd_level(sd_lvl_i, pol_i);
        end else begin
            pin_o = steered;
        end
    end

    // R8
    port_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (pin_o == port_i));

    // R7
    sd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_req_i && en_i && sd_lvl_i == 2'b00) |-> !pin_o);

    // R4
    active_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sd_req_i && pol_i) |-> (pin_o != pwm_i));

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
    parameter int NPINS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [NPINS+2:0]   cfg_wdata,
    input  logic               pwm_i,
    input  logic               period_start_i,
    input  logic [NPINS-1:0]   port_i,
    input  logic               sd_req_i,
    input  logic [1:0]         sd_lvl_ac_i,
    input  logic [1:0]         sd_lvl_bd_i,
    output logic [NPINS-1:0]   pin_o
);

    logic [NPINS-1:0] act_en;
    logic             pol_ac;
    logic             pol_bd;

    pwm_steer_regs #(.NPINS(NPINS)) regs_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .we_i           (cfg_we),
        .wdata_i        (cfg_wdata),
        .period_start_i (period_start_i),
        .act_en_o       (act_en),
        .pol_ac_o       (pol_ac),
        .pol_bd_o       (pol_bd)
    );

    // Even pins (A, C) form one pair, odd pins (B, D) the other
    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        localparam bit ODD = (i % 2) == 1;
        pwm_steer_lane lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (act_en[i]),
            .pwm_i    (pwm_i),
            .port_i   (port_i[i]),
            .pol_i    (ODD ? pol_bd : pol_ac),
            .sd_req_i (sd_req_i),
            .sd_lvl_i (ODD ? sd_lvl_bd_i : sd_lvl_ac_i),
            .pin_o    (pin_o[i])
        );
    end

    // R1
    reset_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en == '0) |-> (pin_o == port_i));

endmodule

// File: tb/pwm_steer_tb.sv
module pwm_steer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       pwm_i = 1'b0;
    logic       period_start_i = 1'b0;
    logic [3:0] port_i = 4'b0000;
    logic       sd_req_i = 1'b0;
    logic [1:0] sd_lvl_ac_i = 2'b00;
    logic [1:0] sd_lvl_bd_i = 2'b00;
    logic [3:0] pin_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_steer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pwm_i(pwm_i), .period_start_i(period_start_i), .port_i(port_i),
        .sd_req_i(sd_req_i), .sd_lvl_ac_i(sd_lvl_ac_i), .sd_lvl_bd_i(sd_lvl_bd_i),
        .pin_o(pin_o)
    );

    task automatic expect_pins(input string req, input logic [3:0] exp);
        #1;
        checks++;
        if (pin_o !== exp) begin
            errors++;
            $display("FAIL %s: pin_o=%b expected=%b", req, pin_o, exp);
        end
    endtask

    // cfg word: {pol_bd, pol_ac, sync, en[3:0]}
    task automatic write_cfg(input logic pbd, input logic pac, input logic sync, input logic [3:0] en);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {pbd, pac, sync, en};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_period();
        @(negedge clk);
        period_start_i = 1'b1;
        @(negedge clk);
        period_start_i = 1'b0;
    endtask

    task automatic t_reset();
        port_i = 4'b1010; pwm_i = 1'b1;
        expect_pins("R1 reset port", 4'b1010);
        pwm_i = 1'b0; port_i = 4'b0110;
        expect_pins("R10 no enables", 4'b0110);
    endtask

    task automatic t_immediate();
        port_i = 4'b1010; pwm_i = 1'b1;
        write_cfg(1'b0, 1'b0, 1'b0, 4'b0101);
        expect_pins("R5 old enables hold", 4'b1010);
        step();
        expect_pins("R5 R2 A,C steered high", 4'b1111);
        pwm_i = 1'b0;
        expect_pins("R2 R3 A,C low, B,D port", 4'b1010);
        write_cfg(1'b0, 1'b0, 1'b0, 4'b1111);
        step();
        pwm_i = 1'b1;
        expect_pins("R2 all four high", 4'b1111);
        pwm_i = 1'b0;
        expect_pins("R2 all four low", 4'b0000);
    endtask

    task automatic t_polarity();
        pwm_i = 1'b1;
        write_cfg(1'b0, 1'b1, 1'b0, 4'b1111);
        step();
        expect_pins("R4 A,C inverted", 4'b1010);
        write_cfg(1'b1, 1'b0, 1'b0, 4'b1111);
        step();
        pwm_i = 1'b0;
        expect_pins("R4 B,D inverted", 4'b1010);
        write_cfg(1'b1, 1'b1, 1'b0, 4'b0000);
        step();
        port_i = 4'b0011;
        expect_pins("R4 port not inverted", 4'b0011);
    endtask

    task automatic t_sync();
        port_i = 4'b0000; pwm_i = 1'b1;
        write_cfg(1'b0, 1'b0, 1'b1, 4'b0011);
        step(); step(); step();
        expect_pins("R6 pending holds", 4'b0000);
        pulse_period();
        expect_pins("R6 applied at period start", 4'b0011);
        // write coinciding with period start
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {1'b0, 1'b0, 1'b1, 4'b1100};
        period_start_i = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; period_start_i = 1'b0;
        expect_pins("R6 coincident pulse ignored", 4'b0011);
        step();
        expect_pins("R6 still waiting", 4'b0011);
        pulse_period();
        expect_pins("R6 applied next period", 4'b1100);
    endtask

    task automatic t_replace();
        port_i = 4'b0000; pwm_i = 1'b1;
        write_cfg(1'b0, 1'b0, 1'b1, 4'b1000);
        write_cfg(1'b0, 1'b0, 1'b1, 4'b0100);
        pulse_period();
        expect_pins("R9 later write wins", 4'b0100);
    endtask

    task automatic t_shutdown();
        port_i = 4'b1010; pwm_i = 1'b1;
        write_cfg(1'b0, 1'b0, 1'b0, 4'b0101);
        step();
        sd_req_i = 1'b1; sd_lvl_ac_i = 2'b00;
        expect_pins("R7 R8 drive low, port kept", 4'b1010);
        pwm_i = 1'b0; sd_lvl_ac_i = 2'b01;
        expect_pins("R7 drive high", 4'b1111);
        sd_lvl_ac_i = 2'b10;
        expect_pins("R7 inactive active-high", 4'b1010);
        write_cfg(1'b0, 1'b1, 1'b0, 4'b0101);
        step();
        sd_lvl_ac_i = 2'b11;
        expect_pins("R7 inactive active-low", 4'b1111);
        port_i = 4'b0000;
        expect_pins("R8 port pins follow port", 4'b0101);
        write_cfg(1'b0, 1'b0, 1'b0, 4'b1010);
        step();
        sd_lvl_bd_i = 2'b01; port_i = 4'b0101;
        expect_pins("R7 R8 B,D forced high", 4'b1111);
        sd_req_i = 1'b0; pwm_i = 1'b0;
        expect_pins("R7 release resumes pwm", 4'b0101);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_immediate();
        t_polarity();
        t_sync();
        t_replace();
        t_shutdown();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule